// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives characters from an idle-high asynchronous serial line. A falling edge on the line marks a start bit. The receiver aligns its bit timer to that edge and samples each bit once, at the middle of the bit period, using an oversampling tick. It collects eight data bits, least significant bit first, into a shift register. When parity is enabled, a parity bit follows. The frame ends with a single stop bit.

At the end of each frame, the character is moved from the shift register into a holding register that the host reads. At the same time a status update is made. A clean frame sets the ready flag. A parity or framing problem sets a sticky error flag, and the character is still delivered. A frame that ends while the previous character is still unread sets the overrun flag, and both the holding register and the ready flag keep their values. Two level interrupt outputs report ready data and errors. One enable input gates both of them.

The host reads the holding register, then pulses the read strobe to drop the ready flag. Each error flag has its own clear strobe. A character is read without loss if the read strobe arrives before the next frame ends.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_data` is zero and every flag and interrupt output is 0.
- R2: A frame is a 0 start bit, then eight data bits with bit 0 first, an optional parity bit, and a stop bit of 1. A clean frame puts the eight bits into `rx_data` and sets `flag_ready`.
- R3: With `parity_en`=1, the data bits plus the parity bit must hold an even number of ones when `parity_odd`=0, or an odd number when `parity_odd`=1. On a mismatch `flag_par` is set, `rx_data` still takes the data, and `flag_ready` stays 0.
- R4: With `parity_en`=0 there is no parity bit: the stop bit is sampled straight after bit 7, and `flag_par` is never set.
- R5: A stop bit sampled as 0 sets `flag_frm`. `rx_data` still takes the data, and `flag_ready` stays 0.
- R6: A frame that ends while `flag_ready` is 1 sets `flag_ovr`. It leaves `rx_data` and `flag_ready` unchanged and sets neither `flag_par` nor `flag_frm`.
- R7: A pulse on `rd_ack` clears `flag_ready`. If the pulse comes before the next frame ends, consecutive frames are received with no overrun.
- R8: `flag_ovr`, `flag_par` and `flag_frm` stay set until a pulse on their own clear strobe (`clr_ovr`, `clr_par`, `clr_frm`). Later frames and the other strobes leave them set.
- R9: `irq_rx` is `irq_en` AND `flag_ready`. `irq_err` is `irq_en` AND (any of the three error flags).
- R10: A start bit that reads 1 at its midpoint is ignored. The receiver returns to idle and no flag or data changes.
- R11: A new frame starts only on a 1-to-0 transition of the line. A line held low after a framing error starts no frame until it has gone back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One pulse per oversample period (OVERSAMPLE per bit) |
| parity_en | input | 1 | 1: a parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| irq_en | input | 1 | Enables both interrupt outputs |
| rd_ack | input | 1 | Host has read `rx_data`; clears the ready flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| clr_par | input | 1 | Clears the parity-error flag |
| clr_frm | input | 1 | Clears the framing-error flag |
| rx_data | output | DATA_BITS | Holding register with the last delivered character |
| flag_ready | output | 1 | A character is ready to read |
| flag_ovr | output | 1 | Overrun, sticky |
| flag_par | output | 1 | Parity error, sticky |
| flag_frm | output | 1 | Framing error, sticky |
| irq_rx | output | 1 | Receive-data interrupt (level) |
| irq_err | output | 1 | Receive-error interrupt (level) |

## Verification
The bench builds the block with DATA_BITS=8 and OVERSAMPLE=4, and holds `baud_tick` high on every cycle, so one frame takes about fifty clocks. At that length, every one of the 256 characters can be sent in each of the three parity settings: none, even and odd. This checks bit order and parity arithmetic over the whole character space rather than a few samples. The same short frames leave room for directed cases: overrun with a bad parity bit, a read that falls in the middle of the next frame, a held-low line after a framing error, a one-cycle start glitch, and a stop error with parity disabled.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver.
// Assumes: only the modules of the serial receiver import it.
package srx_pkg;

    // Bit-timing states of the frame engine
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    // Error outcome of one completed frame
    typedef struct packed {
        logic par_bad;
        logic stop_bad;
    } frame_err_t;

endpackage

// File: rtl/srx_sync.sv
// Multi-flop synchronizer that brings the asynchronous serial line into the clock domain.
// Assumes: STAGES >= 2; the reset value is the idle level of the line.
module srx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe;

    // Shift the raw line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RESET_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
// Frame engine: finds the start edge, times each bit from the oversampling tick,
// samples the bit at mid-period and shifts the data in LSB first. When the stop bit
// is sampled it pulses done for one clock, with the word and the error outcome.
// Assumes: line is already synchronized; parity settings stay constant during a frame;
// OVERSAMPLE >= 4 and DATA_BITS >= 2.
module srx_framer
    import srx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line,
    input  logic                 tick,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    output logic                 done,
    output logic [DATA_BITS-1:0] word,
    output frame_err_t           err
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_e            st;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit;
    logic                 line_prev;
    logic                 at_mid;
    logic                 at_last;

    assign at_mid  = (cnt == MID_CNT);
    assign at_last = (cnt == LAST_CNT);
    assign word    = shreg;

    // Bit timing, sampling and frame sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            line_prev <= 1'b1;
            done      <= 1'b0;
            err       <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                line_prev <= line;
                if (st == RX_IDLE) begin
                    if (line_prev && !line) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end else begin
                    cnt <= at_last ? '0 : cnt + 1'b1;
                    unique case (st)
                        RX_START: begin
                            if (at_mid && line) begin
                                st <= RX_IDLE;
                            end else if (at_last) begin
                                st  <= RX_DATA;
                                idx <= '0;
                            end
                        end
                        RX_DATA: begin
                            if (at_mid) begin
                                shreg <= {line, shreg[DATA_BITS-1:1]};
                            end
                            if (at_last) begin
                                if (idx == LAST_IDX) begin
                                    st <= parity_en ? RX_PARITY : RX_STOP;
                                end else begin
                                    idx <= idx + 1'b1;
                                end
                            end
                        end
                        RX_PARITY: begin
                            if (at_mid) begin
                                par_bit <= line;
                            end
                            if (at_last) begin
                                st <= RX_STOP;
                            end
                        end
                        RX_STOP: begin
                            if (at_mid) begin
                                st           <= RX_IDLE;
                                done         <= 1'b1;
                                err.stop_bad <= !line;
                                err.par_bad  <= parity_en &&
                                                (par_bit != ((^shreg) ^ parity_odd));
                            end
                        end
                        default: st <= RX_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/srx_status.sv
// Holding register, status flags and interrupt gating. On each completed frame it
// decides between overrun, error delivery and clean delivery.
// Assumes: done is a one-clock pulse; a read strobe in the same clock as done counts first.
module srx_status
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] word,
    input  frame_err_t           err,
    input  logic                 rd_ack,
    input  logic                 clr_ovr,
    input  logic                 clr_par,
    input  logic                 clr_frm,
    input  logic                 irq_en,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 flag_ready,
    output logic                 flag_ovr,
    output logic                 flag_par,
    output logic                 flag_frm,
    output logic                 irq_rx,
    output logic                 irq_err
);

    logic [DATA_BITS-1:0] data_n;
    logic                 ready_n;
    logic                 ovr_n;
    logic                 par_n;
    logic                 frm_n;

    // Next flag and data values from strobes and frame outcome
    always_comb begin
        data_n  = rx_data;
        ready_n = flag_ready & ~rd_ack;
        ovr_n   = flag_ovr & ~clr_ovr;
        par_n   = flag_par & ~clr_par;
        frm_n   = flag_frm & ~clr_frm;
        if (done) begin
            if (ready_n) begin
                ovr_n = 1'b1;
            end else begin
                data_n = word;
                if (err.par_bad) begin
                    par_n = 1'b1;
                end
                if (err.stop_bad) begin
                    frm_n = 1'b1;
                end
                if (!(err.par_bad || err.stop_bad)) begin
                    ready_n = 1'b1;
                end
            end
        end
    end

    // Register data and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            flag_ready <= 1'b0;
            flag_ovr   <= 1'b0;
            flag_par   <= 1'b0;
            flag_frm   <= 1'b0;
        end else begin
            rx_data    <= data_n;
            flag_ready <= ready_n;
            flag_ovr   <= ovr_n;
            flag_par   <= par_n;
            flag_frm   <= frm_n;
        end
    end

    assign irq_rx  = irq_en & flag_ready;
    assign irq_err = irq_en & (flag_ovr | flag_par | flag_frm);

endmodule

// File: rtl/serial_rx_core.sv
// Top of the asynchronous serial receiver: synchronizer, frame engine, status block.
// Assumes: baud_tick pulses OVERSAMPLE times per bit period; control inputs are
// synchronous to clk.
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd_in,
    input  logic                 baud_tick,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 irq_en,
    input  logic                 rd_ack,
    input  logic                 clr_ovr,
    input  logic                 clr_par,
    input  logic                 clr_frm,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 flag_ready,
    output logic                 flag_ovr,
    output logic                 flag_par,
    output logic                 flag_frm,
    output logic                 irq_rx,
    output logic                 irq_err
);

    logic                 line_s;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_word;
    frame_err_t           frm_err;

    srx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd_in),
        .dout  (line_s)
    );

    srx_framer #(
        .DATA_BITS  (DATA_BITS),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (line_s),
        .tick       (baud_tick),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .done       (frm_done),
        .word       (frm_word),
        .err        (frm_err)
    );

    srx_status #(
        .DATA_BITS (DATA_BITS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (frm_done),
        .word       (frm_word),
        .err        (frm_err),
        .rd_ack     (rd_ack),
        .clr_ovr    (clr_ovr),
        .clr_par    (clr_par),
        .clr_frm    (clr_frm),
        .irq_en     (irq_en),
        .rx_data    (rx_data),
        .flag_ready (flag_ready),
        .flag_ovr   (flag_ovr),
        .flag_par   (flag_par),
        .flag_frm   (flag_frm),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );

endmodule

// File: rtl/serial_rx_core_chk.sv
// Port-level checker for the serial receiver, bound to every instance of the top.
// Assumes: observes ports only; seen masks the first clock after reset release.
module serial_rx_core_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_en,
    input logic                 rd_ack,
    input logic                 clr_ovr,
    input logic                 clr_par,
    input logic                 clr_frm,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 flag_ready,
    input logic                 flag_ovr,
    input logic                 flag_par,
    input logic                 flag_frm,
    input logic                 irq_rx,
    input logic                 irq_err
);

    logic seen;

    // Mark that one clock has passed since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else begin
            seen <= 1'b1;
        end
    end

    assert_ovr_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(flag_ovr)) |-> ($stable(rx_data) && flag_ready));

    assert_frm_no_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(flag_frm)) |-> !flag_ready);

    assert_par_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(flag_par)) |-> !flag_ready);

    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flag_ready)) |-> $past(rd_ack));

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flag_ovr)) |-> $past(clr_ovr));

    assert_par_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flag_par)) |-> $past(clr_par));

    assert_frm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $fell(flag_frm)) |-> $past(clr_frm));

    assert_data_with_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$stable(rx_data)) |-> ((flag_ready || flag_par || flag_frm) && !$rose(flag_ovr)));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!irq_rx && !irq_err));

endmodule

bind serial_rx_core serial_rx_core_chk #(
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .rd_ack     (rd_ack),
    .clr_ovr    (clr_ovr),
    .clr_par    (clr_par),
    .clr_frm    (clr_frm),
    .rx_data    (rx_data),
    .flag_ready (flag_ready),
    .flag_ovr   (flag_ovr),
    .flag_par   (flag_par),
    .flag_frm   (flag_frm),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err)
);

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
// Self-checking bench: full character sweep in three parity settings, then directed
// error, overrun, timing and glitch cases. Inputs change and outputs are sampled on
// the falling clock edge.
module serial_rx_core_tb;

    localparam int DW = 8;
    localparam int OS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          tick = 1'b1;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          ien = 1'b0;
    logic          rd_ack = 1'b0;
    logic          clr_ovr = 1'b0;
    logic          clr_par = 1'b0;
    logic          clr_frm = 1'b0;
    logic [DW-1:0] rx_data;
    logic          flag_ready, flag_ovr, flag_par, flag_frm, irq_rx, irq_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    serial_rx_core #(
        .DATA_BITS   (DW),
        .OVERSAMPLE  (OS),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_in     (rxd),
        .baud_tick  (tick),
        .parity_en  (par_en),
        .parity_odd (par_odd),
        .irq_en     (ien),
        .rd_ack     (rd_ack),
        .clr_ovr    (clr_ovr),
        .clr_par    (clr_par),
        .clr_frm    (clr_frm),
        .rx_data    (rx_data),
        .flag_ready (flag_ready),
        .flag_ovr   (flag_ovr),
        .flag_par   (flag_par),
        .flag_frm   (flag_frm),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Packed view: {data, ready, ovr, par, frm, irq_rx, irq_err}
    function automatic logic [31:0] snap();
        return {18'd0, rx_data, flag_ready, flag_ovr, flag_par, flag_frm, irq_rx, irq_err};
    endfunction

    function automatic logic [31:0] want(logic [7:0] d, logic r, logic o, logic p,
                                         logic f, logic ir, logic ie);
        return {18'd0, d, r, o, p, f, ir, ie};
    endfunction

    function automatic logic pbit(logic [7:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic v);
        rxd = v;
        cycles(OS);
    endtask

    task automatic send_frame(logic [7:0] d, logic with_par, logic pv, logic stop, int hold_low);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (with_par) send_bit(pv);
        send_bit(stop);
        if (hold_low > 0) begin
            rxd = 1'b0;
            cycles(hold_low);
        end
        rxd = 1'b1;
        cycles(3 * OS);
    endtask

    task automatic pulse_rd();
        rd_ack = 1'b1;
        cycles(1);
        rd_ack = 1'b0;
        cycles(1);
    endtask

    task automatic pulse_clr(int which);
        if (which == 0) clr_ovr = 1'b1;
        if (which == 1) clr_par = 1'b1;
        if (which == 2) clr_frm = 1'b1;
        cycles(1);
        clr_ovr = 1'b0;
        clr_par = 1'b0;
        clr_frm = 1'b0;
        cycles(1);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        check("R1 reset state", snap(), want(8'h00, 0, 0, 0, 0, 0, 0));

        // Sweep all characters: mode 0 no parity, 1 even, 2 odd
        for (int m = 0; m < 3; m++) begin
            par_en  = (m != 0);
            par_odd = (m == 2);
            for (int b = 0; b < 256; b++) begin
                logic [7:0] d;
                d   = 8'(b);
                ien = d[0];
                send_frame(d, par_en, pbit(d, par_odd), 1'b1, 0);
                check("R2 R3 R4 R9 clean frame", snap(), want(d, 1, 0, 0, 0, d[0], 0));
                pulse_rd();
                check("R7 read clears ready", {30'd0, flag_ready, irq_rx}, 32'd0);
            end
        end

        // Parity error still delivers data
        ien = 1'b1; par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'hA5, 1'b1, ~pbit(8'hA5, 1'b0), 1'b1, 0);
        check("R3 R9 parity error", snap(), want(8'hA5, 0, 0, 1, 0, 0, 1));
        send_frame(8'h3C, 1'b1, pbit(8'h3C, 1'b0), 1'b1, 0);
        check("R8 parity flag sticky", snap(), want(8'h3C, 1, 0, 1, 0, 1, 1));
        pulse_clr(1);
        check("R8 clear parity", snap(), want(8'h3C, 1, 0, 0, 0, 1, 0));
        pulse_rd();

        // Framing error followed by a held-low line
        send_frame(8'h81, 1'b1, pbit(8'h81, 1'b0), 1'b0, 6 * OS);
        check("R5 R11 framing error, held low", snap(), want(8'h81, 0, 0, 0, 1, 0, 1));
        send_frame(8'h55, 1'b1, pbit(8'h55, 1'b0), 1'b1, 0);
        check("R11 recovers after line high", snap(), want(8'h55, 1, 0, 0, 1, 1, 1));
        pulse_clr(2);
        pulse_rd();

        // Parity disabled: stop bit directly after bit 7
        par_en = 1'b0;
        send_frame(8'h0F, 1'b0, 1'b0, 1'b0, 0);
        check("R4 stop follows data", snap(), want(8'h0F, 0, 0, 0, 1, 0, 1));
        pulse_clr(2);
        par_en = 1'b1;

        // Overrun with a bad parity bit on the lost frame
        send_frame(8'h11, 1'b1, pbit(8'h11, 1'b0), 1'b1, 0);
        send_frame(8'h22, 1'b1, ~pbit(8'h22, 1'b0), 1'b1, 0);
        check("R6 overrun keeps data", snap(), want(8'h11, 1, 1, 0, 0, 1, 1));
        pulse_clr(1);
        pulse_clr(2);
        check("R8 other strobes leave overrun", snap(), want(8'h11, 1, 1, 0, 0, 1, 1));
        pulse_clr(0);
        check("R8 clear overrun", snap(), want(8'h11, 1, 0, 0, 0, 1, 0));
        pulse_rd();

        // Read during the next frame gives loss-free back-to-back reception
        send_frame(8'h66, 1'b1, pbit(8'h66, 1'b0), 1'b1, 0);
        check("R2 first of pair", snap(), want(8'h66, 1, 0, 0, 0, 1, 0));
        fork
            send_frame(8'h99, 1'b1, pbit(8'h99, 1'b0), 1'b1, 0);
            begin
                cycles(3 * OS);
                pulse_rd();
            end
        join
        check("R7 back-to-back no overrun", snap(), want(8'h99, 1, 0, 0, 0, 1, 0));
        pulse_rd();

        // Interrupt enable low masks both outputs
        ien = 1'b0;
        send_frame(8'h44, 1'b1, ~pbit(8'h44, 1'b0), 1'b1, 0);
        check("R9 masked error irq", snap(), want(8'h44, 0, 0, 1, 0, 0, 0));
        ien = 1'b1;
        cycles(1);
        check("R9 unmasked error irq", {31'd0, irq_err}, 32'd1);
        pulse_clr(1);

        // One-clock start glitch
        rxd = 1'b0;
        cycles(1);
        rxd = 1'b1;
        cycles(6 * OS);
        check("R10 glitch ignored", snap(), want(8'h44, 0, 0, 0, 0, 0, 0));
        send_frame(8'h5A, 1'b1, pbit(8'h5A, 1'b0), 1'b1, 0);
        check("R10 frame after glitch", snap(), want(8'h5A, 1, 0, 0, 0, 1, 0));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule